// File: doc/BRIEF.md
# PPS-aligned PLL sync pulse generator

This block sends a one-cycle SYNC pulse to an external clock-distribution PLL. The pulse is timed from a rising edge of the pulse-per-second (PPS) input. Software arms the block by raising a trigger level. The block then waits for the next PPS rising edge. It counts a fixed base latency of two cycles plus an 8-bit programmable extra delay, fires SYNC, and raises a done flag.

The trigger does not clear itself. Software holds it high until done is reported, then lowers it, and that clears done. If the trigger is withdrawn before SYNC fires, the sequence is abandoned and no pulse is issued. The PPS input is expected to be already synchronous to the block clock.

In the requirements, a "PPS rising edge" is the clock edge at which `pps_in` is first sampled high after being sampled low.

Top module: `pps_sync_pulse`

## Requirements
- R1: While reset is held and on the first cycle after it, `sync_out` and `sync_done` are 0.
- R2: With `extra_delay` = 0, `sync_out` goes high on the clock edge that falls 2 cycles after an accepted PPS rising edge.
- R3: `extra_delay` = D, read as an unsigned 8-bit value, adds D cycles to that latency. D = 3 gives 5 cycles and D = 255 gives 257 cycles.
- R4: A PPS rising edge is accepted only if `arm` was sampled high on an earlier clock edge and has stayed high since. An edge sampled on the same clock edge as the first high sample of `arm` is ignored.
- R5: `sync_out` is high for exactly one cycle per firing.
- R6: `sync_done` rises one cycle after `sync_out` rises and stays high for as long as `arm` stays high.
- R7: `sync_done` returns to 0 one cycle after `arm` is sampled low.
- R8: Only one SYNC pulse is issued per arming. Later PPS rising edges are ignored while `arm` stays high.
- R9: Lowering `arm` before SYNC fires aborts the sequence, with no SYNC pulse and `sync_done` kept low. The next arming then works normally.
- R10: PPS is edge-sensitive. If PPS is already high when the block arms, it does not fire until PPS goes low and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pps_in | input | 1 | PPS level, already in the `clk` domain |
| arm | input | 1 | Trigger level, held high by software until done |
| extra_delay | input | 8 | Cycles added to the 2-cycle base latency |
| sync_out | output | 1 | One-cycle SYNC pulse to the PLL |
| sync_done | output | 1 | Sequence complete; cleared when `arm` drops |

## Verification
The bench drives inputs on falling edges and samples outputs on falling edges, each one half-cycle after the rising edge it refers to. It counts falling edges from the PPS rise until `sync_out` is first seen high. One of those counts is the sampling edge of the PPS itself, so the measured latency is the count minus one, which must equal 2 + D. `sync_done` is due one cycle after that pulse, and `sync_out` must already be low on that same sample. `sync_done` must be low on the first sample after `arm` is dropped. Each "nothing happens" case (an abort, a PPS edge on the arming edge, PPS already high, extra PPS edges after done) is watched for a window longer than the programmed latency before the next stimulus.

// File: rtl/pps_sync_pulse.sv
module pps_sync_pulse #(
  parameter int DELAY_W      = 8,
  parameter int BASE_LATENCY = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pps_in,
  input  logic               arm,
  input  logic [DELAY_W-1:0] extra_delay,
  output logic               sync_out,
  output logic               sync_done
);

  localparam int CNT_W = DELAY_W + 2;
  localparam logic [CNT_W-1:0] BASE_LOAD = CNT_W'(BASE_LATENCY - 1);

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_COUNT, S_DONE} state_t;

  state_t           state;
  logic             pps_q;
  logic [CNT_W-1:0] cnt;
  logic             pps_rise;

  assign pps_rise = pps_in & ~pps_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      pps_q     <= 1'b0;
      cnt       <= '0;
      sync_out  <= 1'b0;
      sync_done <= 1'b0;
    end else begin
      pps_q    <= pps_in;
      sync_out <= 1'b0;
      if (!arm) begin
        state     <= S_IDLE;
        sync_done <= 1'b0;
      end else begin
        case (state)
          S_IDLE:  state <= S_ARMED;
          S_ARMED: if (pps_rise) begin
            cnt   <= CNT_W'(extra_delay) + BASE_LOAD;
            state <= S_COUNT;
          end
          S_COUNT: if (cnt == '0) begin
            sync_out <= 1'b1;
            state    <= S_DONE;
          end else begin
            cnt <= cnt - 1'b1;
          end
          default: sync_done <= sync_out | sync_done;
        endcase
      end
    end
  end

endmodule

module pps_sync_pulse_chk (
  input logic clk,
  input logic rst,
  input logic arm,
  input logic sync_out,
  input logic sync_done
);

  a_r5_single_cycle: assert property (@(posedge clk) disable iff (rst)
    sync_out |=> !sync_out);

  a_r6_done_follows_sync: assert property (@(posedge clk) disable iff (rst)
    (sync_out && arm) |=> sync_done);

  a_r7_done_clears: assert property (@(posedge clk) disable iff (rst)
    !arm |=> (!sync_done && !sync_out));

  a_r8_no_pulse_after_done: assert property (@(posedge clk) disable iff (rst)
    sync_done |-> !sync_out);

  a_r4_fire_needs_arm: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_out) |-> $past(arm));

endmodule

bind pps_sync_pulse pps_sync_pulse_chk u_chk (
  .clk(clk), .rst(rst), .arm(arm), .sync_out(sync_out), .sync_done(sync_done)
);

// File: tb/pps_sync_pulse_test.sv
module pps_sync_pulse_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pps_in = 1'b0;
  logic       arm = 1'b0;
  logic [7:0] extra_delay = 8'd0;
  logic       sync_out;
  logic       sync_done;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #4 clk = ~clk;

  pps_sync_pulse uut (
    .clk(clk), .rst(rst), .pps_in(pps_in), .arm(arm),
    .extra_delay(extra_delay), .sync_out(sync_out), .sync_done(sync_done)
  );

  // {extra_delay[15:8], arm-to-PPS gap in cycles[7:0]}
  localparam logic [15:0] VEC [6] = '{
    {8'd0, 8'd1}, {8'd3, 8'd2}, {8'd1, 8'd5},
    {8'd7, 8'd1}, {8'd255, 8'd3}, {8'd20, 8'd4}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Raise PPS and count cycles to the SYNC edge; returns -1 if none.
  task automatic fire_and_measure(output int lat);
    int n = 0;
    lat = -1;
    pps_in = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      n++;
      if (n == 2) pps_in = 1'b0;
      if (sync_out) begin
        lat = n - 1;
        break;
      end
    end
  endtask

  task automatic watch_quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sync_out || sync_done) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  task automatic release_arm();
    arm = 1'b0;
    @(negedge clk);
    check(!sync_done && !sync_out, "R7", int'(sync_done), 0);
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int lat;
    cycles(3);
    check(!sync_out && !sync_done, "R1 in reset", int'(sync_out | sync_done), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!sync_out && !sync_done, "R1 after reset", int'(sync_out | sync_done), 0);

    foreach (VEC[v]) begin
      extra_delay = VEC[v][15:8];
      arm = 1'b1;
      cycles(int'(VEC[v][7:0]));
      fire_and_measure(lat);
      check(lat == 2 + int'(VEC[v][15:8]), VEC[v][15:8] == 0 ? "R2" : "R3", lat, 2 + int'(VEC[v][15:8]));
      @(negedge clk);
      check(!sync_out, "R5", int'(sync_out), 0);
      check(sync_done, "R6", int'(sync_done), 1);
      cycles(3);
      check(sync_done, "R6 hold", int'(sync_done), 1);
      release_arm();
      cycles(2);
    end

    // R8: further PPS edges while still armed
    extra_delay = 8'd2;
    arm = 1'b1;
    cycles(2);
    fire_and_measure(lat);
    check(lat == 4, "R3", lat, 4);
    cycles(3);
    pps_in = 1'b1; cycles(2); pps_in = 1'b0; cycles(3);
    pps_in = 1'b1; cycles(2); pps_in = 1'b0;
    begin
      int pulses = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (sync_out) pulses++;
      end
      check(pulses == 0 && sync_done, "R8", pulses, 0);
    end
    release_arm();

    // R4: PPS rise on the same edge as the first arm sample
    extra_delay = 8'd1;
    arm = 1'b1;
    pps_in = 1'b1;
    cycles(2);
    pps_in = 1'b0;
    watch_quiet(10, "R4 same-edge ignored");
    fire_and_measure(lat);
    check(lat == 3, "R4 next edge fires", lat, 3);
    cycles(1);
    release_arm();

    // R10: PPS already high when arming
    pps_in = 1'b1;
    cycles(2);
    arm = 1'b1;
    watch_quiet(10, "R10 level ignored");
    pps_in = 1'b0;
    cycles(1);
    fire_and_measure(lat);
    check(lat == 3, "R10 fresh edge", lat, 3);
    cycles(1);
    release_arm();

    // R9: abort mid-count
    extra_delay = 8'd10;
    arm = 1'b1;
    cycles(2);
    pps_in = 1'b1;
    cycles(2);
    pps_in = 1'b0;
    cycles(3);
    arm = 1'b0;
    watch_quiet(20, "R9 abort");
    arm = 1'b1;
    cycles(1);
    fire_and_measure(lat);
    check(lat == 12, "R9 rearm", lat, 12);
    cycles(1);
    release_arm();

    // R1: reset in the middle of an armed wait
    arm = 1'b1;
    extra_delay = 8'd0;
    cycles(2);
    pps_in = 1'b1;
    rst = 1'b1;
    cycles(1);
    pps_in = 1'b0;
    cycles(3);
    check(!sync_out && !sync_done, "R1 mid-sequence", int'(sync_out | sync_done), 0);
    rst = 1'b0;
    arm = 1'b0;
    cycles(5);
    finish_run();
  end

endmodule